// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is a slave-only endpoint on a two-wire serial bus. It gives a bus master read and write access to a bank of 8-bit control registers that sit outside the block and are selected by an 8-bit register index. The clock line is only an input. The data line is open-drain, so the block has a pull-low enable output and a separate input that carries the resolved level of the wire. Both bus lines are oversampled by the system clock through synchroniser flip-flops. A START is an SDA fall while SCL is high, and a STOP is an SDA rise while SCL is high.

A write transaction has this order:
- START.
- Device address with the direction bit at 0.
- Register index.
- One data byte.
- STOP.

The slave acknowledges each of these bytes. A read transaction has this order:
- The address and register index bytes, as for a write.
- A repeated START.
- Device address with the direction bit at 1.
- The slave returns one byte, MSB first, taken from the register read port.
- The master answers with NACK, then STOP.

The fixed device address is binary 0101101. The slave completes a write only after the data byte has been fully acknowledged. At that point it hands the write to the register file as one beat on a valid/ready stream.

Back-pressure rules for the write stream:
- A beat stays presented, with its index and data unchanged, until the register file raises `wr_ready`.
- Another write can complete while a beat is still waiting. In that case the new write is dropped and the waiting beat is kept.
- The register file is expected to accept within the bus idle time between transactions.

The read port is a plain index/data pair. The register file returns `rd_data` for `rd_addr` in the same cycle.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset the block does not pull SDA low (`sda_oe` = 0) and presents no write beat (`wr_valid` = 0).
- R2: A first byte whose upper 7 bits are 0101101 is acknowledged: `sda_oe` pulls SDA low during the ninth SCL high period.
- R3: A first byte with any other 7-bit address is not acknowledged. No later byte is acknowledged and no write results until the next START.
- R4: In a write transaction the slave acknowledges the register index and the data byte. It then raises `wr_valid` with `wr_addr` equal to the index byte and `wr_data` equal to the data byte, bits received MSB first.
- R5: In a read transaction (index write, repeated START, address with direction bit 1) the slave acknowledges the address. It then drives the value of `rd_data` for `rd_addr` equal to the stored index, MSB first, over the next 8 SCL clocks.
- R6: A STOP or a START that arrives before the data byte's acknowledge clock has finished aborts the transaction, and no write beat results.
- R7: `wr_valid` stays high with `wr_addr` and `wr_data` stable until `wr_ready` is high. Exactly one beat is delivered per accepted write. A write that completes while a beat is still waiting is dropped.
- R8: Only one data byte is taken per write transaction. Any further byte before STOP is not acknowledged and produces no beat.
- R9: `sda_oe` changes only while SCL is low.
- R10: After the 8 bits of a read byte the slave releases SDA, so the master's acknowledge bit is seen unaltered on the line. The slave then ignores the bus until START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Resolved serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| rd_addr | output | 8 | Register index for reads (the stored index byte) |
| rd_data | input | 8 | Register value for `rd_addr`, returned the same cycle |
| wr_valid | output | 1 | Write beat is presented |
| wr_ready | input | 1 | Register file accepts the beat |
| wr_addr | output | 8 | Register index of the beat |
| wr_data | output | 8 | Data of the beat |

## Verification
Two functions can fall in the same cycle. The first is the read path loading its shift register from the register read port. The second is a write beat to that same register still waiting for `wr_ready`. A second completed write can also arrive while the first beat is still held. The bench provokes both by holding `wr_ready` low, writing one register, writing another, and then reading the first register back over the bus. It judges the result against its own register model: the read must return the old value, the held beat must keep its original index and data, the second write must vanish, and exactly one beat must land once `wr_ready` rises.

// File: rtl/i2c_regbank_pkg.sv
package i2c_regbank_pkg;

  // Protocol phases of the slave engine.
  typedef enum logic [2:0] {
    PH_IDLE,   // waiting for START
    PH_DEV,    // receiving device address + direction
    PH_ACK,    // driving acknowledge for the last byte
    PH_REG,    // receiving register index
    PH_WDAT,   // receiving data byte
    PH_RDAT,   // transmitting data byte
    PH_HOLD    // transaction done, ignore until START/STOP
  } phase_t;

  localparam int unsigned BYTE_BITS = 8;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= scl_i;
          sda_q <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= {scl_q[STAGES-2:0], scl_i};
          sda_q <= {sda_q[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_q[LAST];
  assign sda_s = sda_q[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
  import i2c_regbank_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'b0101101,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] idx,
  output logic              commit,
  output logic [DATA_W-1:0] commit_data
);
  localparam int unsigned CW = $clog2(BYTE_BITS + 1);
  localparam logic [CW-1:0] FULL = CW'(BYTE_BITS);
  localparam logic [CW-1:0] LASTB = CW'(BYTE_BITS - 1);

  phase_t ph, after_ack;
  logic [BYTE_BITS-1:0] sh;
  logic [CW-1:0] cnt;
  logic receiving;

  assign receiving = (ph == PH_DEV) || (ph == PH_REG) || (ph == PH_WDAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph          <= PH_IDLE;
      after_ack   <= PH_IDLE;
      sh          <= '0;
      cnt         <= '0;
      sda_oe      <= 1'b0;
      idx         <= '0;
      commit      <= 1'b0;
      commit_data <= '0;
    end else begin
      commit <= 1'b0;
      if (start_det) begin
        ph     <= PH_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        ph     <= PH_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (receiving) begin
        if (scl_rise && cnt < FULL) begin
          sh  <= {sh[BYTE_BITS-2:0], sda_s};
          cnt <= cnt + 1'b1;
        end else if (scl_fall && cnt == FULL) begin
          cnt <= '0;
          if (ph == PH_DEV) begin
            if (sh[7:1] == DEV_ADDR) begin
              sda_oe    <= 1'b1;
              ph        <= PH_ACK;
              after_ack <= sh[0] ? PH_RDAT : PH_REG;
            end else begin
              ph <= PH_IDLE;
            end
          end else if (ph == PH_REG) begin
            idx       <= sh[ADDR_W-1:0];
            sda_oe    <= 1'b1;
            ph        <= PH_ACK;
            after_ack <= PH_WDAT;
          end else begin
            commit_data <= sh[DATA_W-1:0];
            sda_oe      <= 1'b1;
            ph          <= PH_ACK;
            after_ack   <= PH_HOLD;
          end
        end
      end else if (ph == PH_ACK) begin
        if (scl_fall) begin
          ph <= after_ack;
          if (after_ack == PH_RDAT) begin
            sh     <= rd_data[BYTE_BITS-1:0];
            sda_oe <= ~rd_data[BYTE_BITS-1];
          end else begin
            sda_oe <= 1'b0;
          end
          if (after_ack == PH_HOLD) commit <= 1'b1;
        end
      end else if (ph == PH_RDAT) begin
        if (scl_fall) begin
          if (cnt == LASTB) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            ph     <= PH_HOLD;
          end else begin
            cnt    <= cnt + 1'b1;
            sh     <= {sh[BYTE_BITS-2:0], 1'b0};
            sda_oe <= ~sh[BYTE_BITS-2];
          end
        end
      end
    end
  end

endmodule

// File: rtl/i2c_wr_stage.sv
module i2c_wr_stage #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [ADDR_W-1:0] commit_addr,
  input  logic [DATA_W-1:0] commit_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic slot_free;
  assign slot_free = !wr_valid || wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (commit && slot_free) begin
        wr_valid <= 1'b1;
        wr_addr  <= commit_addr;
        wr_data  <= commit_data;
      end
    end
  end

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter logic [6:0]  DEV_ADDR    = 7'b0101101,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic commit;
  logic [DATA_W-1:0] commit_data;
  logic [ADDR_W-1:0] idx;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_proto_fsm #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sda_s       (sda_s),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .rd_data     (rd_data),
    .sda_oe      (sda_oe),
    .idx         (idx),
    .commit      (commit),
    .commit_data (commit_data)
  );

  i2c_wr_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit),
    .commit_addr (idx),
    .commit_data (commit_data),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data)
  );

  assign rd_addr = idx;

endmodule

// File: rtl/i2c_regbank_slave_chk.sv
module i2c_regbank_slave_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_i,
  input logic              sda_oe,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);
  // R9: the pull-low enable only moves while SCL is low
  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R7: a waiting beat holds its payload until accepted
  p_beat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R4: a beat appears only after the acknowledge clock has ended (SCL low)
  p_commit_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> !scl_i);

  // R2: when the slave pulls low, the line reads low
  p_drive_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> !sda_i);

endmodule

bind i2c_regbank_slave i2c_regbank_slave_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .sda_i    (sda_i),
  .sda_oe   (sda_oe),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data)
);

// File: tb/i2c_regbank_slave_test.sv
module i2c_regbank_slave_test;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'b0101101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic wr_ready = 1'b1;
  logic sda_oe, wr_valid;
  logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
  wire sda_line = ~(m_low | sda_oe);

  logic [7:0] mem [0:255];
  logic [7:0] exp_mem [0:255];
  int beats = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_regbank_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assign rd_data = mem[rd_addr];

  always @(posedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      mem[wr_addr] <= wr_data;
      beats <= beats + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_low = 0; tick(Q);
    m_scl = 1; tick(Q);
    m_low = 1; tick(Q);
    m_scl = 0; tick(Q);
  endtask

  task automatic bus_stop();
    m_low = 1; tick(Q);
    m_scl = 1; tick(Q);
    m_low = 0; tick(Q);
  endtask

  task automatic clk_bit(input bit b);
    m_low = ~b; tick(Q);
    m_scl = 1; tick(2*Q);
    m_scl = 0; tick(Q);
  endtask

  // sends 8 bits and runs the acknowledge clock; checks R9 on the ack bit
  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit a0, a1;
    for (int i = 7; i >= 0; i--) clk_bit(b[i]);
    m_low = 0; tick(Q);
    m_scl = 1; tick(1);
    a0 = sda_line; tick(2*Q - 2);
    a1 = sda_line;
    chk(a0 == a1, "R9 ack level steady while SCL high", a1, a0);
    tick(1);
    m_scl = 0; tick(Q);
    ack = !a1;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit nack);
    for (int i = 7; i >= 0; i--) begin
      m_low = 0; tick(Q);
      m_scl = 1; tick(Q);
      b[i] = sda_line; tick(Q);
      m_scl = 0; tick(Q);
    end
    m_low = ~nack; tick(Q);
    m_scl = 1; tick(Q);
    chk(sda_line == nack, "R10 master ack bit seen unaltered", sda_line, nack);
    tick(Q);
    m_scl = 0; tick(Q);
  endtask

  task automatic do_write(input logic [7:0] r, input logic [7:0] d, input bit expect_beat);
    bit a;
    int b0;
    b0 = beats;
    bus_start();
    send_byte({DEV, 1'b0}, a); chk(a, "R2 address ack on write", a, 1);
    send_byte(r, a);           chk(a, "R4 index ack", a, 1);
    send_byte(d, a);           chk(a, "R4 data ack", a, 1);
    bus_stop();
    if (expect_beat && wr_ready) begin
      chk(beats == b0 + 1, "R4 one beat per write", beats, b0 + 1);
      exp_mem[r] = d;
    end
  endtask

  task automatic do_read(input logic [7:0] r, output logic [7:0] v);
    bit a;
    bus_start();
    send_byte({DEV, 1'b0}, a); chk(a, "R2 address ack before read", a, 1);
    send_byte(r, a);           chk(a, "R5 index ack", a, 1);
    bus_start();
    send_byte({DEV, 1'b1}, a); chk(a, "R5 read address ack", a, 1);
    recv_byte(v, 1'b1);
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'((i * 7) + 3);
      exp_mem[i] = 8'((i * 7) + 3);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    bit a;
    logic [7:0] v;
    int b0;
    tick(5);
    // R1 reset state
    chk(sda_oe == 0, "R1 sda_oe after reset", sda_oe, 0);
    chk(wr_valid == 0, "R1 wr_valid after reset", wr_valid, 0);
    rst_n = 1;
    tick(5);
    chk(sda_oe == 0 && wr_valid == 0, "R1 idle after reset release", {sda_oe, wr_valid}, 0);

    // R2 / R3: sweep all device addresses
    for (int ad = 0; ad < 128; ad++) begin
      bus_start();
      send_byte({7'(ad), 1'b0}, a);
      if (7'(ad) == DEV) chk(a, "R2 matching address acked", a, 1);
      else begin
        chk(!a, "R3 foreign address not acked", a, 0);
        send_byte(8'h5A, a);
        chk(!a, "R3 later byte after mismatch not acked", a, 0);
      end
      bus_stop();
    end
    chk(beats == 0, "R3 no beat from sweep", beats, 0);

    // R4: writes to spread-out registers
    for (int k = 0; k < 12; k++) begin
      do_write(8'(k * 23 + 1), 8'((k * 41) ^ 8'hA5), 1);
      chk(wr_addr == 8'(k * 23 + 1), "R4 beat index", wr_addr, 8'(k * 23 + 1));
      chk(wr_data == 8'((k * 41) ^ 8'hA5), "R4 beat data", wr_data, 8'((k * 41) ^ 8'hA5));
    end

    // R5: read back written and untouched registers
    for (int k = 0; k < 16; k++) begin
      logic [7:0] r;
      r = (k < 12) ? 8'(k * 23 + 1) : 8'(k * 5 + 200);
      do_read(r, v);
      chk(v == exp_mem[r], "R5 read value", v, exp_mem[r]);
    end

    // R6: STOP inside the data byte
    b0 = beats;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h40, a);
    for (int i = 0; i < 4; i++) clk_bit(1'b1);
    bus_stop();
    chk(beats == b0, "R6 STOP mid data makes no beat", beats, b0);
    // R6: repeated START inside the data byte
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h41, a);
    for (int i = 0; i < 5; i++) clk_bit(1'b0);
    bus_start();
    bus_stop();
    chk(beats == b0, "R6 START mid data makes no beat", beats, b0);
    do_read(8'h40, v); chk(v == exp_mem[8'h40], "R6 register 40 untouched", v, exp_mem[8'h40]);
    do_read(8'h41, v); chk(v == exp_mem[8'h41], "R6 register 41 untouched", v, exp_mem[8'h41]);

    // R8: second data byte refused
    b0 = beats;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h50, a);
    send_byte(8'h11, a); chk(a, "R8 first data byte acked", a, 1);
    send_byte(8'h22, a); chk(!a, "R8 second data byte not acked", a, 0);
    bus_stop();
    exp_mem[8'h50] = 8'h11;
    chk(beats == b0 + 1, "R8 exactly one beat", beats, b0 + 1);
    do_read(8'h50, v); chk(v == 8'h11, "R8 register holds first byte", v, 8'h11);

    // R7: back-pressure, drop while pending, read during pending beat
    b0 = beats;
    wr_ready = 0;
    do_write(8'h60, 8'h77, 0);
    tick(20);
    chk(wr_valid == 1, "R7 beat held", wr_valid, 1);
    chk(wr_addr == 8'h60 && wr_data == 8'h77, "R7 held payload", {wr_addr, wr_data}, 16'h6077);
    do_write(8'h61, 8'h88, 0);
    chk(wr_addr == 8'h60 && wr_data == 8'h77, "R7 later write dropped", {wr_addr, wr_data}, 16'h6077);
    do_read(8'h60, v);
    chk(v == exp_mem[8'h60], "R7 read sees old value while beat waits", v, exp_mem[8'h60]);
    wr_ready = 1;
    tick(3);
    chk(beats == b0 + 1, "R7 single beat after release", beats, b0 + 1);
    chk(wr_valid == 0, "R7 valid drops after accept", wr_valid, 0);
    exp_mem[8'h60] = 8'h77;
    do_read(8'h60, v); chk(v == 8'h77, "R7 held write landed", v, 8'h77);
    do_read(8'h61, v); chk(v == exp_mem[8'h61], "R7 dropped write absent", v, exp_mem[8'h61]);

    finish_up();
  end

endmodule